// File: doc/BRIEF.md
# Register-mapped serial port front end

This block is the register side of a simple serial port. A processor reaches it through a 32-bit slave bus that accepts whole-word accesses only. The address is given as a word index, which is the byte offset divided by four. The line side is abstracted to two byte streams:

- received bytes arrive as a byte with a one-cycle strobe and are queued in a 16-entry circular FIFO;
- each write to the transmit data register is sent straight out as a byte with a one-cycle strobe.

One level interrupt line reports the flags that software has unmasked.

Software drains received data through two views of the same status/data word. The peek view only inspects the oldest byte. The pop view also removes that byte. Writing the transmit data register raises two transmit flags. The first acknowledge after such a write is not allowed to clear flag 0, so software has to acknowledge that flag a second time. Bit-level framing, baud timing, parity, DMA and any transmit queue lie outside this block.

Top module: `sport_regs`

Word index map (byte offset in brackets):

| Index | Offset | Register |
|---|---|---|
| 0 | 0x00 | transmit control |
| 1 | 0x04 | transmit DMA enable |
| 2 | 0x08 | receive control |
| 7 | 0x1C | transmit data |
| 8 | 0x20 | status/data, pop view |
| 9 | 0x24 | status/data, peek view |
| 11 | 0x2C | interrupt mask |
| 12 | 0x30 | interrupt acknowledge |
| 13 | 0x34 | raw interrupt |
| 14 | 0x38 | masked interrupt |

## Requirements
- R1: After reset the receive control register reads 0x00010000. The transmit control, DMA enable, transmit data, mask, acknowledge, raw and masked registers read 0. The FIFO is empty and irq_o is low.
- R2: A status/data word has bit 24 (transmitter ready) and bit 22 (transmitter idle) always at 1. Bit 16 is 1 exactly when the FIFO holds a byte. Bits 7:0 hold the oldest byte, or 0 when the FIFO is empty. All other bits are 0.
- R3: A read at index 9 returns the status/data word and leaves the FIFO unchanged. A read at index 8 returns the same word and removes the oldest byte, but only when the FIFO is not empty.
- R4: A byte with rx_strobe high is accepted at that clock edge only while receive control bit 3 is 1 and fewer than 16 bytes are held. Otherwise it is dropped. Accepted bytes leave the FIFO in arrival order.
- R5: When a pop read and an accepted byte fall in the same cycle, the oldest byte is removed, the new byte is appended and the byte count is unchanged.
- R6: Raw interrupt bit 3 is 1 exactly while the FIFO is non-empty, whatever acknowledge writes are made.
- R7: A write at index 7 drives tx_strobe high in that same cycle with tx_byte equal to bus_wdata[7:0]. From the next cycle raw interrupt bits 0 and 1 are 1, and a pending-transmit flag is set.
- R8: A write at index 12 clears the raw bits 0 and 1 that are 1 in the value. If the pending-transmit flag is set, bit 0 is removed from the value first and the flag is cleared. The register reads back the value after this adjustment.
- R9: The masked interrupt register reads raw AND mask. irq_o is 1 exactly when that value is non-zero.
- R10: Indices 0, 1, 2, 7 and 11 store all 32 written bits and read them back. Indices 8, 9, 13 and 14 ignore writes. Unmapped indices 3 to 6, 10 and 15 read 0 and ignore writes. bus_rdata is 0 in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock, rising edge |
| rst_n | input | 1 | asynchronous active-low reset |
| bus_req | input | 1 | access this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_word | input | 4 | word index (byte offset / 4) |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data, valid in the access cycle |
| rx_strobe | input | 1 | received byte valid |
| rx_byte | input | 8 | received byte |
| tx_strobe | output | 1 | transmit byte valid |
| tx_byte | output | 8 | transmit byte |
| irq_o | output | 1 | level interrupt |

## Verification
The hardest states to reach from the ports are a completely full FIFO that receives a further byte, and a pop read that lands on the same cycle as an incoming byte at either end of the count. The stimulus reaches them by enabling the receiver, streaming seventeen bytes back to back, and then popping while new bytes keep arriving. The acknowledge quirk is reached by interleaving transmit writes with acknowledge writes that do and do not include bit 0. A long seeded mix of random accesses and strobes then runs against the reference queue to cover wrap-around of the pointers.

// File: rtl/sport_regs.sv
module sport_regs #(
  parameter int PW = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_req,
  input  logic        bus_we,
  input  logic [3:0]  bus_word,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        rx_strobe,
  input  logic [7:0]  rx_byte,
  output logic        tx_strobe,
  output logic [7:0]  tx_byte,
  output logic        irq_o
);
  localparam int DEPTH = 1 << PW;
  localparam logic [PW:0] FULL_CNT = DEPTH[PW:0];
  localparam logic [3:0] W_TXCTL = 4'd0, W_TXDMA = 4'd1, W_RXCTL = 4'd2,
                         W_DOUT  = 4'd7, W_POP   = 4'd8, W_PEEK  = 4'd9,
                         W_MASK  = 4'd11, W_ACK  = 4'd12, W_RAW  = 4'd13,
                         W_MSKD  = 4'd14;

  logic [31:0] txctl_q, txdma_q, rxctl_q, dout_q, mask_q, ack_q;
  logic [1:0]  txf_q;
  logic        pend_q;
  logic [7:0]  mem [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [PW:0] cnt_q;

  wire wr_en = bus_req & bus_we;
  wire rd_en = bus_req & ~bus_we;
  wire empty = (cnt_q == '0);
  wire full  = (cnt_q == FULL_CNT);
  wire pop   = rd_en & (bus_word == W_POP) & ~empty;
  wire push  = rx_strobe & rxctl_q[3] & ~full;
  wire ack_wr = wr_en & (bus_word == W_ACK);
  wire [31:0] ack_val = pend_q ? (bus_wdata & ~32'd1) : bus_wdata;

  wire [31:0] raw    = {28'd0, ~empty, 1'b0, txf_q};
  wire [31:0] masked = raw & mask_q;
  wire [7:0]  head   = empty ? 8'd0 : mem[rd_q];
  wire [31:0] status = {7'd0, 1'b1, 1'b0, 1'b1, 5'd0, ~empty, 8'd0, head};

  assign irq_o     = |masked;
  assign tx_strobe = wr_en & (bus_word == W_DOUT);
  assign tx_byte   = bus_wdata[7:0];

  always_comb begin
    bus_rdata = 32'd0;
    if (rd_en) begin
      case (bus_word)
        W_TXCTL: bus_rdata = txctl_q;
        W_TXDMA: bus_rdata = txdma_q;
        W_RXCTL: bus_rdata = rxctl_q;
        W_DOUT:  bus_rdata = dout_q;
        W_POP, W_PEEK: bus_rdata = status;
        W_MASK:  bus_rdata = mask_q;
        W_ACK:   bus_rdata = ack_q;
        W_RAW:   bus_rdata = raw;
        W_MSKD:  bus_rdata = masked;
        default: bus_rdata = 32'd0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txctl_q <= 32'd0;
      txdma_q <= 32'd0;
      rxctl_q <= 32'h0001_0000;
      dout_q  <= 32'd0;
      mask_q  <= 32'd0;
      ack_q   <= 32'd0;
      txf_q   <= 2'b00;
      pend_q  <= 1'b0;
    end else if (wr_en) begin
      case (bus_word)
        W_TXCTL: txctl_q <= bus_wdata;
        W_TXDMA: txdma_q <= bus_wdata;
        W_RXCTL: rxctl_q <= bus_wdata;
        W_MASK:  mask_q  <= bus_wdata;
        W_DOUT: begin
          dout_q <= bus_wdata;
          txf_q  <= 2'b11;
          pend_q <= 1'b1;
        end
        W_ACK: begin
          ack_q  <= ack_val;
          txf_q  <= txf_q & ~ack_val[1:0];
          pend_q <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= wr_q + 1'b1;
      if (pop)  rd_q <= rd_q + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);
  // R4
  rx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_strobe && !rxctl_q[3] && !pop) |=> $stable(cnt_q));
  // R4
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);
  // R5
  pop_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && push) |=> $stable(cnt_q));
  // R3
  peek_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && bus_word == W_PEEK && !rx_strobe) |=> $stable(cnt_q));
  // R7
  tx_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_strobe |=> (txf_q == 2'b11) && pend_q);
  // R8
  ack_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && pend_q) |=> (txf_q[0] == $past(txf_q[0])) && !pend_q);
  // R9
  irq_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q[3] && cnt_q != '0) |-> irq_o);
endmodule

// File: tb/sport_regs_tb_top.sv
module sport_regs_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n, bus_req, bus_we, rx_strobe, tx_strobe, irq_o;
  logic [3:0] bus_word;
  logic [31:0] bus_wdata, bus_rdata;
  logic [7:0] rx_byte, tx_byte;

  sport_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_strobe(rx_strobe), .rx_byte(rx_byte), .tx_strobe(tx_strobe),
    .tx_byte(tx_byte), .irq_o(irq_o)
  );

  byte unsigned q[$];
  logic [31:0] m_txctl, m_txdma, m_rxctl, m_dout, m_mask, m_ack;
  logic [1:0] m_txf;
  bit m_pend;
  int total = 0, bad = 0;
  bit done = 0;

  function automatic logic [31:0] m_raw();
    return {28'd0, q.size() != 0, 1'b0, m_txf};
  endfunction

  function automatic logic [31:0] m_status();
    logic [31:0] s;
    s = 32'h0140_0000;
    if (q.size() != 0) s = s | 32'h0001_0000 | {24'd0, q[0]};
    return s;
  endfunction

  function automatic logic [31:0] m_read(input logic [3:0] a);
    case (a)
      4'd0: return m_txctl;
      4'd1: return m_txdma;
      4'd2: return m_rxctl;
      4'd7: return m_dout;
      4'd8, 4'd9: return m_status();
      4'd11: return m_mask;
      4'd12: return m_ack;
      4'd13: return m_raw();
      4'd14: return m_raw() & m_mask;
      default: return 32'd0;
    endcase
  endfunction

  task automatic step(input bit req, input bit we, input logic [3:0] a,
                      input logic [31:0] d, input bit rs, input logic [7:0] rb,
                      input string tag);
    logic [31:0] e_rd;
    bit e_txs, e_irq, acc;
    int old;
    @(negedge clk);
    bus_req = req; bus_we = we; bus_word = a; bus_wdata = d;
    rx_strobe = rs; rx_byte = rb;
    #1;
    e_rd  = (req && !we) ? m_read(a) : 32'd0;
    e_txs = req && we && (a == 4'd7);
    e_irq = |(m_raw() & m_mask);
    total++;
    if (bus_rdata !== e_rd || tx_strobe !== e_txs || irq_o !== e_irq ||
        (e_txs && tx_byte !== d[7:0])) begin
      bad++;
      $display("FAIL %s: rdata=%h tx=%b/%h irq=%b expected rdata=%h tx=%b/%h irq=%b",
               tag, bus_rdata, tx_strobe, tx_byte, irq_o, e_rd, e_txs, d[7:0], e_irq);
    end
    @(posedge clk);
    old = q.size();
    acc = rs && m_rxctl[3] && old < 16;
    if (req && !we && a == 4'd8 && old > 0) void'(q.pop_front());
    if (acc) q.push_back(rb);
    if (req && we) begin
      case (a)
        4'd0: m_txctl = d;
        4'd1: m_txdma = d;
        4'd2: m_rxctl = d;
        4'd11: m_mask = d;
        4'd7: begin m_dout = d; m_txf = 2'b11; m_pend = 1; end
        4'd12: begin
          m_ack = m_pend ? (d & ~32'd1) : d;
          m_txf = m_txf & ~m_ack[1:0];
          m_pend = 0;
        end
        default: ;
      endcase
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input string tag);
    step(1, 1, a, d, 0, 8'd0, tag);
  endtask
  task automatic rd(input logic [3:0] a, input string tag);
    step(1, 0, a, 32'd0, 0, 8'd0, tag);
  endtask
  task automatic rx(input logic [7:0] b, input string tag);
    step(0, 0, 4'd0, 32'd0, 1, b, tag);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run=expired expected=complete");
      summary();
      $finish;
    end
  end

  initial begin
    m_txctl = 0; m_txdma = 0; m_rxctl = 32'h0001_0000; m_dout = 0;
    m_mask = 0; m_ack = 0; m_txf = 0; m_pend = 0;
    rst_n = 0; bus_req = 0; bus_we = 0; bus_word = 0; bus_wdata = 0;
    rx_strobe = 0; rx_byte = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state, R2 status format when empty
    for (int i = 0; i < 16; i++) rd(i[3:0], "R1");
    rd(4'd9, "R2");
    // R4 receiver disabled at reset: byte dropped
    rx(8'h11, "R4");
    rd(4'd9, "R4");
    // R10 plain registers
    wr(4'd0, 32'hDEAD_BEEF, "R10"); rd(4'd0, "R10");
    wr(4'd1, 32'h1234_5678, "R10"); rd(4'd1, "R10");
    wr(4'd4, 32'hFFFF_FFFF, "R10"); rd(4'd4, "R10");
    wr(4'd13, 32'hFFFF_FFFF, "R10"); rd(4'd13, "R10");
    wr(4'd9, 32'hFFFF_FFFF, "R10"); rd(4'd15, "R10");
    // R4 enable receiver, queue bytes; R3 peek/pop
    wr(4'd2, 32'h0000_0008, "R10"); rd(4'd2, "R10");
    rx(8'hA1, "R4"); rx(8'hB2, "R4"); rx(8'hC3, "R4");
    rd(4'd9, "R3"); rd(4'd9, "R3"); rd(4'd13, "R6");
    wr(4'd12, 32'h0000_0008, "R6"); rd(4'd13, "R6");
    wr(4'd11, 32'h0000_0008, "R9"); rd(4'd14, "R9");
    rd(4'd8, "R3"); rd(4'd8, "R3"); rd(4'd8, "R3");
    rd(4'd8, "R3"); rd(4'd9, "R2"); rd(4'd13, "R6");
    // R4 fill to 16, drop 17th
    for (int i = 0; i < 17; i++) rx(8'h40 + i[7:0], "R4");
    rd(4'd9, "R4");
    // R5 pop with incoming byte on full FIFO (byte dropped) and otherwise
    step(1, 0, 4'd8, 0, 1, 8'hEE, "R5");
    step(1, 0, 4'd8, 0, 1, 8'hEF, "R5");
    for (int i = 0; i < 17; i++) rd(4'd8, "R5");
    step(1, 0, 4'd8, 0, 1, 8'h77, "R5");
    rd(4'd9, "R5"); rd(4'd8, "R5"); rd(4'd9, "R5");
    // R7 transmit write, R8 acknowledge quirk, R9 irq
    wr(4'd11, 32'h0000_000F, "R9");
    wr(4'd7, 32'h0000_01A5, "R7"); rd(4'd13, "R7"); rd(4'd7, "R7");
    wr(4'd12, 32'h0000_0003, "R8"); rd(4'd12, "R8"); rd(4'd13, "R8");
    wr(4'd12, 32'h0000_0001, "R8"); rd(4'd13, "R8"); rd(4'd14, "R9");
    wr(4'd7, 32'h0000_005A, "R7");
    wr(4'd12, 32'h0000_0002, "R8"); rd(4'd13, "R8");
    wr(4'd12, 32'h0000_0001, "R8"); rd(4'd13, "R8");
    wr(4'd7, 32'h0000_00C3, "R7"); wr(4'd7, 32'h0000_003C, "R7");
    wr(4'd11, 32'h0000_0002, "R9"); rd(4'd14, "R9");
    wr(4'd12, 32'hFFFF_FFFF, "R8"); rd(4'd13, "R8");
    wr(4'd12, 32'hFFFF_FFFF, "R8"); rd(4'd13, "R8");

    // seeded mix across all requirements
    void'($urandom(32'h5EED));
    for (int i = 0; i < 4000; i++) begin
      int sel;
      logic [3:0] a;
      logic [31:0] d;
      sel = $urandom_range(0, 9);
      a = (sel < 4) ? 4'd8 : (sel < 5) ? 4'd9 : $urandom_range(0, 15);
      d = $urandom;
      if (a == 4'd2 && sel != 9) d[3] = 1'b1;
      step($urandom_range(0, 3) != 0, (a != 4'd8 && a != 4'd9) && $urandom_range(0, 1) == 1,
           a, d, $urandom_range(0, 1) == 1, $urandom, "R5");
    end

    done = 1;
    summary();
    $finish;
  end
endmodule